// File: doc/BRIEF.md
# Addend-Driven Precision Time Counter

This block keeps the 64-bit time base of a precision time protocol clock. A 32-bit phase accumulator takes in a programmable increment on every clock. Each carry out of that addition advances two 64-bit counters by one tick. One is the adjustable system time and the other is a free-running raw time. One tick stands for 16 ns, so software shifts the count left by four to get nanoseconds. Software trims the clock frequency in fine steps by writing the increment: nominal ± nominal × ppb / 1e9, with the nominal value 0xF0000029. The largest correction is 66,666,655 ppb, so the increment always stays below 2^32. With a 66.67 MHz clock and the nominal increment, ticks arrive at 62.5 MHz.

Software reaches the block over a simple 32-bit register port. The system time is loaded with two writes: the low word first, then the high word, which commits all 64 bits at once. It is read in the same order: reading the low word freezes a copy of the high word, so the two halves belong together. A 64-bit target can be programmed. When target mode is on and the system time has reached the target, a pending flag sets and drives the interrupt line. Software clears the flag by writing a one to it.

Register offsets (byte addresses): control 0x00, event 0x04, increment 0x08, accumulator 0x0C, test 0x10, raw time low/high 0x18/0x1C, system time low/high 0x20/0x24, target low/high 0x28/0x2C.

Top module: `tick_timekeeper`

## Requirements
- R1: After reset the increment register reads 0xF0000029. Control, event, accumulator, target, system time, raw time and bus_rdata all read 0, and irq is low.
- R2: Every clock adds the increment into the 32-bit accumulator (offset 0x0C). Each carry out of that addition advances both the system time and the raw time by exactly one in the same cycle. A write to 0x0C replaces the accumulator and gives no carry in that cycle. A write to 0x08 affects the additions from the next cycle on.
- R3: A write to 0x20 only stages the low word. A write to 0x24 loads the system time with {written value, staged low word} in one cycle, and this load takes priority over a tick in that cycle. The raw time is not affected.
- R4: A read of 0x20 returns the system time low word and captures its high word. A later read of 0x24 returns that captured word, even if the counter has moved on. The raw time behaves the same way at 0x18/0x1C.
- R5: Read data appears on bus_rdata in the cycle after the bus_rd strobe. It holds until the next read.
- R6: Control bit 1 is the target mode enable and reads back. While it is 0, the pending flag never sets.
- R7: Writing 1 to control bit 0 clears the accumulator, system time, raw time and pending flag in that cycle, taking priority over all other updates. That bit always reads 0.
- R8: Event bit 1 sets in the cycle after the system time is ≥ the 64-bit target while target mode is on. It stays set until a 1 is written to it. Writing a 0 does nothing, and a clear while the condition still holds leaves it set.
- R9: irq is the OR of all event register bits.
- R10: The increment, accumulator and target registers are writable and read back. Any other offset, including 0x10, reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt, OR of the event bits |

## Verification
Some rules are checked by properties on every cycle:
- the counters move by at most one tick and wrap only on a carry;
- a high-word write loads the counter exactly, and a soft reset clears it;
- the pending flag rises only when the comparison holds, and holds until it is cleared;
- read data stays stable between reads.

Other behaviour only the bench scenarios can show: the cadence of ticks for a given increment, the consistency of a captured high word read long after its low word, the precedence of a load over a tick, and the clear-while-still-true case. The bench checks these against a behavioural model.

// File: rtl/tk_pkg.sv
package tk_pkg;
  // byte offsets decoded by software drivers
  localparam logic [7:0] OFF_CTRL    = 8'h00;
  localparam logic [7:0] OFF_EVENT   = 8'h04;
  localparam logic [7:0] OFF_ADDEND  = 8'h08;
  localparam logic [7:0] OFF_ACCUM   = 8'h0C;
  localparam logic [7:0] OFF_RAW_LO  = 8'h18;
  localparam logic [7:0] OFF_RAW_HI  = 8'h1C;
  localparam logic [7:0] OFF_SYS_LO  = 8'h20;
  localparam logic [7:0] OFF_SYS_HI  = 8'h24;
  localparam logic [7:0] OFF_TGT_LO  = 8'h28;
  localparam logic [7:0] OFF_TGT_HI  = 8'h2C;
  // bit positions
  localparam int CTL_SRST_BIT   = 0;
  localparam int CTL_TGT_EN_BIT = 1;
  localparam int EVT_TGT_BIT    = 1;
endpackage

// File: rtl/tk_phase_acc.sv
module tk_phase_acc #(
  parameter int ACC_W = 32,
  parameter logic [ACC_W-1:0] ADD_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add_we,
  input  logic             acc_we,
  input  logic [ACC_W-1:0] wdata,
  output logic [ACC_W-1:0] addend_o,
  output logic [ACC_W-1:0] acc_o,
  output logic             tick_o
);
  function automatic logic [ACC_W:0] phase_sum(input logic [ACC_W-1:0] a,
                                               input logic [ACC_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [ACC_W-1:0] acc_q, add_q;
  logic [ACC_W:0]   sum_w;

  assign sum_w    = phase_sum(acc_q, add_q);
  assign tick_o   = sum_w[ACC_W] & ~clr & ~acc_we;
  assign addend_o = add_q;
  assign acc_o    = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      add_q <= ADD_RST;
    end else begin
      if (add_we) add_q <= wdata;
      if (clr)         acc_q <= '0;
      else if (acc_we) acc_q <= wdata;
      else             acc_q <= sum_w[ACC_W-1:0];
    end
  end

  // R2
  wrap_on_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> acc_q < $past(acc_q));
  // R2
  grow_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_o && !clr && !acc_we) |=> acc_q >= $past(acc_q));
endmodule

// File: rtl/tk_time_core.sv
module tk_time_core #(
  parameter int TIME_W   = 64,
  parameter bit LOADABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic              ld,
  input  logic [TIME_W-1:0] ld_val,
  output logic [TIME_W-1:0] cnt_o
);
  logic [TIME_W-1:0] cnt_q;
  logic              ld_eff;

  assign ld_eff = LOADABLE & ld;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (ld_eff) cnt_q <= ld_val;
    else             cnt_q <= cnt_q + {{(TIME_W-1){1'b0}}, tick};
  end

  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld_eff) |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
  // R3
  exact_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_eff && !clr) |=> cnt_q == $past(ld_val));
  // R7
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
endmodule

// File: rtl/tk_target_event.sv
module tk_target_event #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              mode_en,
  input  logic              w1c,
  input  logic [TIME_W-1:0] now,
  input  logic [TIME_W-1:0] target,
  output logic              pend_o
);
  function automatic logic reached(input logic [TIME_W-1:0] t,
                                   input logic [TIME_W-1:0] goal);
    return t >= goal;
  endfunction

  logic pend_q, hit_w;

  assign hit_w  = mode_en & reached(now, target);
  assign pend_o = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= 1'b0;
    else if (clr) pend_q <= 1'b0;
    else          pend_q <= hit_w | (pend_q & ~w1c);
  end

  // R8
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(hit_w));
  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr && !w1c) |=> pend_q);
endmodule

// File: rtl/tick_timekeeper.sv
module tick_timekeeper
  import tk_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] ADDEND_RST = 32'hF000_0029
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int TIME_W = 2 * DATA_W;

  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  logic              soft_rst, mode_q, tick, pend;
  logic              add_we, acc_we, sys_ld, w1c;
  logic [DATA_W-1:0] addend, accum, stage_lo, sys_hi_cap, raw_hi_cap, rdata_q, rd_val;
  logic [DATA_W-1:0] evt_vec;
  logic [TIME_W-1:0] sys_time, raw_time, tgt_q;

  assign soft_rst = bus_wr & at(bus_addr, OFF_CTRL) & bus_wdata[CTL_SRST_BIT];
  assign w1c      = bus_wr & at(bus_addr, OFF_EVENT) & bus_wdata[EVT_TGT_BIT];
  assign add_we   = bus_wr & at(bus_addr, OFF_ADDEND);
  assign acc_we   = bus_wr & at(bus_addr, OFF_ACCUM);
  assign sys_ld   = bus_wr & at(bus_addr, OFF_SYS_HI);

  tk_phase_acc #(.ACC_W(DATA_W), .ADD_RST(ADDEND_RST)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .add_we(add_we), .acc_we(acc_we),
    .wdata(bus_wdata), .addend_o(addend), .acc_o(accum), .tick_o(tick));

  tk_time_core #(.TIME_W(TIME_W), .LOADABLE(1'b1)) u_sys (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .tick(tick), .ld(sys_ld),
    .ld_val({bus_wdata, stage_lo}), .cnt_o(sys_time));

  tk_time_core #(.TIME_W(TIME_W), .LOADABLE(1'b0)) u_raw (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .tick(tick), .ld(1'b0),
    .ld_val('0), .cnt_o(raw_time));

  tk_target_event #(.TIME_W(TIME_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .mode_en(mode_q), .w1c(w1c),
    .now(sys_time), .target(tgt_q), .pend_o(pend));

  assign evt_vec = DATA_W'(pend) << EVT_TGT_BIT;
  assign irq     = |evt_vec;

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      ADDR_W'(OFF_CTRL):   rd_val = DATA_W'(mode_q) << CTL_TGT_EN_BIT;
      ADDR_W'(OFF_EVENT):  rd_val = evt_vec;
      ADDR_W'(OFF_ADDEND): rd_val = addend;
      ADDR_W'(OFF_ACCUM):  rd_val = accum;
      ADDR_W'(OFF_RAW_LO): rd_val = raw_time[DATA_W-1:0];
      ADDR_W'(OFF_RAW_HI): rd_val = raw_hi_cap;
      ADDR_W'(OFF_SYS_LO): rd_val = sys_time[DATA_W-1:0];
      ADDR_W'(OFF_SYS_HI): rd_val = sys_hi_cap;
      ADDR_W'(OFF_TGT_LO): rd_val = tgt_q[DATA_W-1:0];
      ADDR_W'(OFF_TGT_HI): rd_val = tgt_q[TIME_W-1:DATA_W];
      default:             rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= 1'b0;
      stage_lo   <= '0;
      tgt_q      <= '0;
      sys_hi_cap <= '0;
      raw_hi_cap <= '0;
      rdata_q    <= '0;
    end else begin
      if (bus_wr) begin
        if (at(bus_addr, OFF_CTRL))   mode_q   <= bus_wdata[CTL_TGT_EN_BIT];
        if (at(bus_addr, OFF_SYS_LO)) stage_lo <= bus_wdata;
        if (at(bus_addr, OFF_TGT_LO)) tgt_q[DATA_W-1:0]      <= bus_wdata;
        if (at(bus_addr, OFF_TGT_HI)) tgt_q[TIME_W-1:DATA_W] <= bus_wdata;
      end
      if (bus_rd) begin
        rdata_q <= rd_val;
        if (at(bus_addr, OFF_SYS_LO)) sys_hi_cap <= sys_time[TIME_W-1:DATA_W];
        if (at(bus_addr, OFF_RAW_LO)) raw_hi_cap <= raw_time[TIME_W-1:DATA_W];
      end
    end
  end

  assign bus_rdata = rdata_q;

  // R5
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/tick_timekeeper_tb.sv
module tick_timekeeper_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire         irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timekeeper u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  int checks = 0, failures = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_acc, m_add, m_stage, m_syscap, m_rawcap, m_rdata;
  logic [63:0] m_sys, m_raw, m_tgt;
  logic        m_mode, m_pend;
  string       m_tag = "R5";

  function automatic string tag_of(input logic [5:0] a);
    case (a)
      6'h00: return "R6 ctrl";
      6'h04: return "R8 event";
      6'h0C: return "R2 accum";
      6'h18, 6'h1C: return "R4 raw";
      6'h20, 6'h24: return "R3 systime";
      default: return "R10 reg";
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic [32:0] sum;
    logic hit, tk, clr1, srst;
    logic [31:0] wd;
    if (!rst_n) begin
      m_acc = 0; m_add = 32'hF000_0029; m_stage = 0; m_syscap = 0; m_rawcap = 0;
      m_rdata = 0; m_sys = 0; m_raw = 0; m_tgt = 0; m_mode = 0; m_pend = 0;
    end else begin
      wd = bus_wdata;
      if (bus_rd) begin
        m_tag = tag_of(bus_addr);
        case (bus_addr)
          6'h00: m_rdata = {30'd0, m_mode, 1'b0};
          6'h04: m_rdata = {30'd0, m_pend, 1'b0};
          6'h08: m_rdata = m_add;
          6'h0C: m_rdata = m_acc;
          6'h18: begin m_rdata = m_raw[31:0]; m_rawcap = m_raw[63:32]; end
          6'h1C: m_rdata = m_rawcap;
          6'h20: begin m_rdata = m_sys[31:0]; m_syscap = m_sys[63:32]; end
          6'h24: m_rdata = m_syscap;
          6'h28: m_rdata = m_tgt[31:0];
          6'h2C: m_rdata = m_tgt[63:32];
          default: m_rdata = 0;
        endcase
      end
      hit  = m_mode && (m_sys >= m_tgt);
      sum  = {1'b0, m_acc} + {1'b0, m_add};
      clr1 = bus_wr && bus_addr == 6'h04 && wd[1];
      srst = bus_wr && bus_addr == 6'h00 && wd[0];
      if (clr1) m_pend = 0;
      if (hit)  m_pend = 1;
      if (srst) begin
        m_acc = 0; m_sys = 0; m_raw = 0; m_pend = 0;
      end else begin
        tk    = !(bus_wr && bus_addr == 6'h0C) && sum[32];
        m_acc = (bus_wr && bus_addr == 6'h0C) ? wd : sum[31:0];
        m_raw = m_raw + {63'd0, tk};
        if (bus_wr && bus_addr == 6'h24) m_sys = {wd, m_stage};
        else m_sys = m_sys + {63'd0, tk};
      end
      if (bus_wr) begin
        case (bus_addr)
          6'h00: m_mode = wd[1];
          6'h08: m_add = wd;
          6'h20: m_stage = wd;
          6'h28: m_tgt[31:0] = wd;
          6'h2C: m_tgt[63:32] = wd;
          default: ;
        endcase
      end
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9 irq vs model", {63'd0, irq}, {63'd0, m_pend});
      chk({m_tag, " R5 rdata vs model"}, {32'd0, bus_rdata}, {32'd0, m_rdata});
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    logic [31:0] d, lo, hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset irq", {63'd0, irq}, 64'd0);
    chk("R1 reset rdata", {32'd0, bus_rdata}, 64'd0);
    rd(6'h08, d); chk("R1 increment reset", {32'd0, d}, 64'hF000_0029);
    rd(6'h28, d); chk("R1 target reset", {32'd0, d}, 64'd0);
    rd(6'h00, d); chk("R1 control reset", {32'd0, d}, 64'd0);
    idle(5);
    chk("R6 mode off, no pending though target 0", {63'd0, irq}, 64'd0);

    // frozen clock: exact load and readback
    wr(6'h08, 32'h0); wr(6'h0C, 32'h0);
    wr(6'h20, 32'h89AB_CDEF);
    rd(6'h24, d); chk("R3 low write alone does not load", {32'd0, d}, 64'd0);
    wr(6'h24, 32'h0123_4567);
    rd(6'h20, d); chk("R3 low word loaded", {32'd0, d}, 64'h89AB_CDEF);
    rd(6'h24, d); chk("R3 high word loaded", {32'd0, d}, 64'h0123_4567);
    rd(6'h0C, d); chk("R10 accumulator readback", {32'd0, d}, 64'd0);

    // several increments
    wr(6'h08, 32'h8000_0000); idle(12); rd(6'h20, d); rd(6'h18, d);
    wr(6'h08, 32'hFFFF_FFFF); idle(20); rd(6'h18, d); rd(6'h1C, d); rd(6'h0C, d);
    wr(6'h0C, 32'hFFFF_FFF0); idle(3); rd(6'h0C, d); rd(6'h20, d);

    // captured high word stays consistent
    wr(6'h08, 32'hF000_0029);
    wr(6'h20, 32'hFFFF_FFF0); wr(6'h24, 32'h5);
    rd(6'h20, d); idle(40);
    rd(6'h24, d); chk("R4 captured high word", {32'd0, d}, 64'h5);
    rd(6'h18, d); idle(10); rd(6'h1C, d);

    // target event
    rd(6'h20, lo); rd(6'h24, hi);
    wr(6'h28, lo + 32'd30); wr(6'h2C, hi);
    wr(6'h00, 32'h2); idle(60);
    chk("R8 pending set", {63'd0, irq}, 64'd1);
    rd(6'h04, d); chk("R8 event bit 1 reads set", {32'd0, d}, 64'h2);
    rd(6'h00, d); chk("R6 mode reads back", {32'd0, d}, 64'h2);
    wr(6'h04, 32'h2); idle(2);
    chk("R8 clear while reached stays set", {63'd0, irq}, 64'd1);
    wr(6'h04, 32'h0); idle(2);
    chk("R8 writing 0 keeps flag", {63'd0, irq}, 64'd1);
    wr(6'h00, 32'h0); wr(6'h04, 32'h2); idle(2);
    chk("R8 cleared by one", {63'd0, irq}, 64'd0);
    rd(6'h04, d); chk("R9 event empty", {32'd0, d}, 64'd0);

    // unmapped offsets
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h10, d); chk("R10 test offset reads 0", {32'd0, d}, 64'd0);
    rd(6'h14, d); chk("R10 hole reads 0", {32'd0, d}, 64'd0);

    // load versus tick priority at a fast rate
    wr(6'h08, 32'hFFFF_FFFF); wr(6'h20, 32'h100); wr(6'h24, 32'h0);
    rd(6'h20, d); rd(6'h24, d);

    // soft reset
    wr(6'h08, 32'h0); wr(6'h00, 32'h3);
    rd(6'h20, d); chk("R7 system time cleared", {32'd0, d}, 64'd0);
    rd(6'h18, d); chk("R7 raw time cleared", {32'd0, d}, 64'd0);
    rd(6'h0C, d); chk("R7 accumulator cleared", {32'd0, d}, 64'd0);
    rd(6'h00, d); chk("R7 reset bit self-clears", {32'd0, d}, 64'h2);
    idle(4);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule